// File: doc/BRIEF.md
# Power-On Strap Latch Sequencer

This block sequences five dual-purpose pads that serve as configuration inputs first and as clock outputs afterwards. When the power-good reset is released, it keeps every pad's output driver disabled for a programmable window of reference-clock cycles. During that window the board's pull resistors alone set the pad levels.

At the last cycle of the window, the block captures the five pad levels into strap registers. Four of these form a frequency-select code and the fifth chooses the function of a shared reference/stop pin. The block then turns on the pad drivers one cycle later and raises a ready flag one cycle after that. Until ready is high, the clock values routed to the pads are forced low, so a partly configured clock never reaches the board.

The captured straps keep their values until the power-good reset is asserted again. Nothing else can change them. The strap registers reset to the levels the internal pulls would give: the fourth select bit is low and all the others are high.

Top module: `strap_latch_seq`

## Requirements
- R1: While `pwr_ok_n` is low, and until the strap capture has happened, `pad_oe` is all zeros.
- R2: From reset until the capture, `sel_fs` reads 4'b0111 (bit 3 low, bits 2..0 high) and `sel_mode` reads 1.
- R3: Count the rising edges of `clk_ref` at which `pwr_ok_n` is high, starting after its release. At edge number `WIN_CYCLES`, `sel_fs[i]` takes `pad_in[i]` for i = 0..3 and `sel_mode` takes `pad_in[4]`. The levels at earlier edges do not count.
- R4: `pad_oe` becomes 5'b11111 at edge `WIN_CYCLES`+1 and stays that way until reset.
- R5: `ready` rises at edge `WIN_CYCLES`+2 and stays high until reset.
- R6: `pad_out` is all zeros while `ready` is low. Once `ready` is high, `pad_out` equals `clk_src`.
- R7: After the capture, changes on `pad_in` have no effect on `sel_fs` or `sel_mode`.
- R8: Asserting `pwr_ok_n` low, whether partway through the window or after ready, returns the straps to their R2 values and clears `pad_oe` and `ready`. The next release starts a full new window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Free-running reference clock |
| pwr_ok_n | input | 1 | Synchronous active-low power-good reset |
| pad_in | input | 5 | Sensed pad levels; [3:0] frequency straps, [4] mode strap |
| clk_src | input | 5 | Clock values to present on the pads once ready |
| pad_oe | output | 5 | Pad output-driver enables |
| pad_out | output | 5 | Gated clock values toward the pad drivers |
| sel_fs | output | 4 | Latched frequency-select straps |
| sel_mode | output | 1 | Latched mode strap |
| ready | output | 1 | Sequencer finished; clocks released |

## Verification
The checks are timed by counting the rising edges at which the reset is high: the straps are due after edge `WIN_CYCLES`, the enables after the next edge, and ready and the released clocks after the edge after that. The bench drives every input on the falling edge and samples on the falling edge that follows each counted rising edge. It also changes `pad_in` on the falling edge just before the capture edge, so a capture one cycle early or late shows up as a mismatch. All 32 strap patterns are swept with a short window, and separate passes cover a reset partway through the window and a reset after ready.

// File: rtl/strap_seq_pkg.sv
// Package: shared types and constants for the strap latch sequencer.
// Assumes exactly five dual-purpose pads: [3:0] frequency select, [4] mode.
package strap_seq_pkg;

    localparam int NUM_PADS = 5;
    localparam int FS_BITS  = 4;

    // Reset strap image mirrors the on-chip pulls: FS3 pulled down, rest up.
    localparam logic [NUM_PADS-1:0] STRAP_DEFAULT = 5'b10111;

    typedef enum logic [1:0] {
        SEQ_HIZ   = 2'd0,
        SEQ_LATCH = 2'd1,
        SEQ_DRIVE = 2'd2,
        SEQ_READY = 2'd3
    } seq_state_e;

endpackage

// File: rtl/strap_window_timer.sv
// Module: counts reference-clock cycles of the three-state window.
// Assumes run stays high until expired has been seen; expired is
// combinational and marks the last cycle of the window.
module strap_window_timer #(
    parameter int WIN_CYCLES = 28636
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Advance the window count while running, stopping at the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == LAST);

    // R3: count never leaves the window range
    assert_cnt_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/strap_capture.sv
// Module: strap registers loaded once, on the capture strobe.
// Assumes capture is a single-cycle strobe; only rst_n clears the image.
module strap_capture #(
    parameter int                 NPADS     = 5,
    parameter logic [NPADS-1:0]   RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [NPADS-1:0] pad_in,
    output logic [NPADS-1:0] strap_q,
    output logic             held
);
    // Per-pad strap bit, generated so each pad owns its flop.
    for (genvar i = 0; i < NPADS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                strap_q[i] <= RESET_VAL[i];
            end else if (capture && !held) begin
                strap_q[i] <= pad_in[i];
            end
        end
    end

    // Record that the one-time capture has taken place.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
        end else if (capture) begin
            held <= 1'b1;
        end
    end

    // R7: once held, the strap image never moves
    assert_straps_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> $stable(strap_q));

endmodule

// File: rtl/strap_pad_gate.sv
// Module: pad driver enables and clock gating toward the pads.
// Assumes drive_en is a level that stays high until reset and that ready
// follows drive_en by at least one cycle.
module strap_pad_gate #(
    parameter int NPADS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drive_en,
    input  logic             ready,
    input  logic [NPADS-1:0] clk_src,
    output logic [NPADS-1:0] pad_oe,
    output logic [NPADS-1:0] pad_out
);
    // Register the driver enables so they switch on a clean edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pad_oe <= '0;
        end else begin
            pad_oe <= {NPADS{drive_en}};
        end
    end

    // Hold every clock low until the sequencer reports ready.
    always_comb begin
        pad_out = ready ? clk_src : '0;
    end

    // R4: enables move together as one group
    assert_oe_grouped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe == '0) || (pad_oe == '1));

endmodule

// File: rtl/strap_latch_seq.sv
// Module: top of the power-on strap sequencer. Drives the window timer,
// captures straps at the last window cycle, enables drivers one cycle
// later and reports ready one cycle after that.
// Assumes pwr_ok_n is synchronous to clk_ref.
module strap_latch_seq #(
    parameter int WIN_CYCLES = 28636
) (
    input  logic       clk_ref,
    input  logic       pwr_ok_n,
    input  logic [4:0] pad_in,
    input  logic [4:0] clk_src,
    output logic [4:0] pad_oe,
    output logic [4:0] pad_out,
    output logic [3:0] sel_fs,
    output logic       sel_mode,
    output logic       ready
);
    import strap_seq_pkg::*;

    seq_state_e          state_q, state_d;
    logic                win_run, win_done, capture, strap_held, drive_en;
    logic [NUM_PADS-1:0] strap_img;
    logic                ready_q;

    assign win_run  = (state_q == SEQ_HIZ);
    assign capture  = win_run && win_done;
    assign drive_en = (state_q != SEQ_HIZ);

    strap_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
        .clk     (clk_ref),
        .rst_n   (pwr_ok_n),
        .run     (win_run),
        .expired (win_done)
    );

    strap_capture #(.NPADS(NUM_PADS), .RESET_VAL(STRAP_DEFAULT)) u_capture (
        .clk     (clk_ref),
        .rst_n   (pwr_ok_n),
        .capture (capture),
        .pad_in  (pad_in),
        .strap_q (strap_img),
        .held    (strap_held)
    );

    strap_pad_gate #(.NPADS(NUM_PADS)) u_gate (
        .clk      (clk_ref),
        .rst_n    (pwr_ok_n),
        .drive_en (drive_en),
        .ready    (ready_q),
        .clk_src  (clk_src),
        .pad_oe   (pad_oe),
        .pad_out  (pad_out)
    );

    // Next-state: window, capture, enable, ready, then park.
    always_comb begin
        state_d = state_q;
        case (state_q)
            SEQ_HIZ:   if (win_done) state_d = SEQ_LATCH;
            SEQ_LATCH: state_d = SEQ_DRIVE;
            SEQ_DRIVE: state_d = SEQ_READY;
            default:   state_d = SEQ_READY;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk_ref) begin
        if (!pwr_ok_n) state_q <= SEQ_HIZ;
        else           state_q <= state_d;
    end

    // Ready flag: set on leaving the enable step, sticky until reset.
    always_ff @(posedge clk_ref) begin
        if (!pwr_ok_n)                 ready_q <= 1'b0;
        else if (state_q == SEQ_DRIVE) ready_q <= 1'b1;
    end

    assign sel_fs   = strap_img[FS_BITS-1:0];
    assign sel_mode = strap_img[NUM_PADS-1];
    assign ready    = ready_q;

    // R1: drivers stay off until straps are held
    assert_hiz_in_window_R1: assert property (@(posedge clk_ref) disable iff (!pwr_ok_n)
        !strap_held |-> (pad_oe == '0));

    // R4: drivers switch on only after capture
    assert_oe_after_latch_R4: assert property (@(posedge clk_ref) disable iff (!pwr_ok_n)
        $rose(pad_oe[0]) |-> strap_held);

    // R5: ready never drops without reset
    assert_ready_sticky_R5: assert property (@(posedge clk_ref) disable iff (!pwr_ok_n)
        ready |=> ready);

    // R6: clocks are released only with drivers enabled
    assert_ready_implies_oe_R6: assert property (@(posedge clk_ref) disable iff (!pwr_ok_n)
        ready |-> (pad_oe == 5'b11111));

endmodule

// File: tb/strap_latch_seq_tb.sv
// Bench: sweeps all 32 strap patterns with a short window, plus reset
// partway through the window and reset after ready.
module strap_latch_seq_tb;

    localparam int WIN = 12;
    localparam int MAX_CYC = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] pad_in = '0;
    logic [4:0] clk_src = '0;
    logic [4:0] pad_oe, pad_out;
    logic [3:0] sel_fs;
    logic       sel_mode, ready;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    strap_latch_seq #(.WIN_CYCLES(WIN)) u_dut (
        .clk_ref (clk),
        .pwr_ok_n(rst_n),
        .pad_in  (pad_in),
        .clk_src (clk_src),
        .pad_oe  (pad_oe),
        .pad_out (pad_out),
        .sel_fs  (sel_fs),
        .sel_mode(sel_mode),
        .ready   (ready)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic check_defaults(input string tag);
        check({tag, " R2 fs"}, {28'd0, sel_fs}, 32'h7);
        check({tag, " R2 mode"}, {31'd0, sel_mode}, 32'h1);
        check({tag, " R1 oe"}, {27'd0, pad_oe}, 32'h0);
        check({tag, " R5 ready"}, {31'd0, ready}, 32'h0);
    endtask

    // Reset for a few cycles, then release on a falling edge.
    task automatic power_cycle(input logic [4:0] pre);
        @(negedge clk);
        rst_n = 1'b0;
        pad_in = pre;
        repeat (3) @(negedge clk);
        check_defaults("reset");
        rst_n = 1'b1;
    endtask

    // Run one window from a fresh release; pad levels flip before capture edge.
    task automatic run_window(input logic [4:0] p, input logic [4:0] src);
        clk_src = src;
        for (int k = 1; k <= WIN + 2; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k < WIN) begin
                check("R2 window fs", {28'd0, sel_fs}, 32'h7);
                check("R1 window oe", {27'd0, pad_oe}, 32'h0);
                check("R6 window out", {27'd0, pad_out}, 32'h0);
                if (k == WIN - 1) pad_in = p;
            end else if (k == WIN) begin
                check("R3 fs", {28'd0, sel_fs}, {28'd0, p[3:0]});
                check("R3 mode", {31'd0, sel_mode}, {31'd0, p[4]});
                check("R1 oe at capture", {27'd0, pad_oe}, 32'h0);
            end else if (k == WIN + 1) begin
                check("R4 oe", {27'd0, pad_oe}, 32'h1f);
                check("R5 ready early", {31'd0, ready}, 32'h0);
                check("R6 out gated", {27'd0, pad_out}, 32'h0);
            end else begin
                check("R5 ready", {31'd0, ready}, 32'h1);
                check("R6 out pass", {27'd0, pad_out}, {27'd0, src});
            end
        end
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > MAX_CYC) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, MAX_CYC);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // Full sweep of strap patterns.
        for (int p = 0; p < 32; p++) begin
            power_cycle(~5'(p));
            run_window(5'(p), 5'(p * 7 + 3));
            // R7: pad changes after capture are ignored.
            pad_in = ~5'(p);
            repeat (3) @(negedge clk);
            check("R7 fs held", {28'd0, sel_fs}, {28'd0, 4'(p)});
            check("R7 mode held", {31'd0, sel_mode}, {31'd0, 1'(p >> 4)});
            check("R4 oe held", {27'd0, pad_oe}, 32'h1f);
            clk_src = 5'(p ^ 5'h15);
            #1;
            check("R6 out follows", {27'd0, pad_out}, {27'd0, 5'(p ^ 5'h15)});
        end

        // R8: reset partway through the window restarts it.
        power_cycle(5'h1f);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_defaults("R8 mid-window");
        rst_n = 1'b1;
        pad_in = 5'h1f;
        run_window(5'h0a, 5'h13);

        // R8: reset after ready restores defaults and restarts.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_defaults("R8 after ready");
        check("R8 out", {27'd0, pad_out}, 32'h0);
        rst_n = 1'b1;
        pad_in = 5'h00;
        run_window(5'h11, 5'h0e);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule